// File: doc/BRIEF.md
# Three-Line Vertical Comb Luma/Chroma Separator

This block splits a digitized composite video stream into a luma value and a chroma value. An upstream bandsplit delivers each sample as a low-band part and a high-band part. Two one-line delays align three vertically adjacent samples: the incoming line, the line before it and the line before that. A vertical comb on the high band removes chroma. The middle line is the reference. Combed high-band luma plus the reference low band forms luma. The reference high band minus combed luma forms chroma. The comb weights follow a standard select. For NTSC, where chroma inverts on every line, the weights are a quarter, a half and a quarter. For PAL, the two outer lines, which lie two lines apart, are averaged.

A separate-input mode routes externally split luma and chroma through the same line storage. These samples leave the block after exactly the same delay as combed results, so switching sources does not move the picture. Line length in samples is a runtime input. Typical values are 858, 864, 780 and 944, depending on standard and sampling rate. Internal arithmetic is 12 bits wide. Both outputs are rounded and clipped to 8 bits.

Top module: `comb3_yc_sep`

## Requirements
- R1: Each accepted sample (`in_valid` high) advances a sample position that wraps after `line_len` samples (4 to MAX_LINE). The three taps are the incoming sample, the sample `line_len` accepted samples earlier, and the sample `2*line_len` accepted samples earlier.
- R2: After reset, `out_valid`, `y_out` and `c_out` are 0. `out_valid` goes high exactly one clock after an accepted sample, and only once at least two full lines have been accepted since reset.
- R3: In NTSC mode (`pal_mode`=0), combed high-band luma is hy = floor((new + 2*mid + old + 2)/4), computed on signed high-band values.
- R4: In PAL mode (`pal_mode`=1), hy = floor((new + old + 1)/2). The middle line does not contribute.
- R5: `hi_band` is two's complement and `lo_band` is unsigned. Then `y_out` = lo_mid + hy and `c_out` = 128 + hi_mid − hy, where lo_mid and hi_mid are the middle-line parts.
- R6: Consider an NTSC input with constant low band L, and high band h + s·A(k) with s alternating in sign on every line. Under this input, `y_out` equals L + h, free of chroma, and `c_out` equals 128 + s_mid·A(k).
- R7: With `bypass_en`=1, `y_out` equals `byp_y` and `c_out` equals `byp_c` as presented `line_len` accepted samples earlier. These values emerge with the same latency as combed results and are not combed.
- R8: Results below 0 give 0 and results above 255 give 255, on both outputs.
- R9: A cycle with `in_valid` low advances nothing. It produces no `out_valid`, and later results are the same as if the idle cycle were absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset of position, fill count and outputs |
| in_valid | input | 1 | Sample accepted this cycle |
| line_len | input | 11 | Samples per video line |
| pal_mode | input | 1 | 0 selects NTSC weights, 1 selects PAL weights |
| bypass_en | input | 1 | 1 routes byp_y/byp_c through the delay without combing |
| lo_band | input | 8 | Unsigned low-band part of the composite sample |
| hi_band | input | 8 | Two's complement high-band part of the composite sample |
| byp_y | input | 8 | Separate luma input |
| byp_c | input | 8 | Separate chroma input (offset binary) |
| out_valid | output | 1 | y_out/c_out hold a valid result |
| y_out | output | 8 | Luma output |
| c_out | output | 8 | Chroma output, 128 is zero |

## Verification
A sample position that slips or wraps at the wrong count misaligns the taps. On the alternating-chroma pattern, chroma then leaks into luma. On every sample of the third line, that leak shows as a luma value away from the flat expected level. A wrong fill counter shows as `out_valid` raised during the first two lines, or never raised. An idle cycle that still advances the position corrupts every result that follows it on the next line. The scoreboard compares each result one clock after its sample, so such a fault appears within one line of its cause.

// File: rtl/comb3_pkg.sv
package comb3_pkg;

   typedef enum logic {
      STD_NTSC = 1'b0,
      STD_PAL  = 1'b1
   } comb_std_e;

   // clamp an integer result into 0..hi_lim
   function automatic int clip_range(input int v, input int hi_lim);
      int r;
      if (v < 0)
         r = 0;
      else if (v > hi_lim)
         r = hi_lim;
      else
         r = v;
      return r;
   endfunction

endpackage

// File: rtl/comb3_line_delay.sv
// One video line of storage: read the word written one line ago, then overwrite it.
module comb3_line_delay #(
   parameter int WW    = 16,
   parameter int DEPTH = 1024,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [WW-1:0] din,
   output logic [WW-1:0] dout
);

   logic [WW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[addr] <= din;
   end

   assign dout = mem[addr];

endmodule

// File: rtl/comb3_vweight.sv
// Vertical three-tap weighting of the high band; the standard picks the tap set.
module comb3_vweight #(
   parameter int DW    = 8,
   parameter int IW    = 12,
   parameter bit ROUND = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pal_mode,
   input  logic signed [DW-1:0] tap_new,
   input  logic signed [DW-1:0] tap_mid,
   input  logic signed [DW-1:0] tap_old,
   output logic signed [IW-1:0] hy
);

   localparam logic signed [IW-1:0] HALF_Q = 2;
   localparam logic signed [IW-1:0] HALF_H = 1;

   logic signed [IW-1:0] e_new, e_mid, e_old;
   logic signed [IW-1:0] sum_ntsc, sum_pal;
   logic signed [IW-1:0] hy_ntsc, hy_pal;

   assign e_new    = IW'(tap_new);
   assign e_mid    = IW'(tap_mid);
   assign e_old    = IW'(tap_old);
   assign sum_ntsc = e_new + (e_mid <<< 1) + e_old;
   assign sum_pal  = e_new + e_old;

   generate
      if (ROUND) begin : g_round
         assign hy_ntsc = (sum_ntsc + HALF_Q) >>> 2;
         assign hy_pal  = (sum_pal + HALF_H) >>> 1;
      end else begin : g_trunc
         assign hy_ntsc = sum_ntsc >>> 2;
         assign hy_pal  = sum_pal >>> 1;
      end
   endgenerate

   assign hy = pal_mode ? hy_pal : hy_ntsc;

   // a flat column has no chroma: the comb must return it unchanged (R3, R4)
   assert_flat_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tap_new == tap_mid && tap_mid == tap_old) |-> (hy == e_mid));

   // opposite outer lines cancel completely in PAL
   assert_pal_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pal_mode && e_new == -e_old) |-> (hy == '0));

endmodule

// File: rtl/comb3_yc_sep.sv
module comb3_yc_sep
   import comb3_pkg::*;
#(
   parameter int DW       = 8,
   parameter int IW       = 12,
   parameter int MAX_LINE = 1024,
   parameter bit ROUND    = 1'b1,
   localparam int LEN_W   = $clog2(MAX_LINE + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [LEN_W-1:0] line_len,
   input  logic             pal_mode,
   input  logic             bypass_en,
   input  logic [DW-1:0]    lo_band,
   input  logic [DW-1:0]    hi_band,
   input  logic [DW-1:0]    byp_y,
   input  logic [DW-1:0]    byp_c,
   output logic             out_valid,
   output logic [DW-1:0]    y_out,
   output logic [DW-1:0]    c_out
);

   localparam int AW     = $clog2(MAX_LINE);
   localparam int WW     = 2 * DW;
   localparam int N_DLY  = 2;
   localparam int MAXV   = (1 << DW) - 1;
   localparam int C_ZERO = 1 << (DW - 1);

   generate
      if (IW < DW + 3) begin : g_bad_iw
         $error("comb3_yc_sep: IW too narrow for three-tap sum");
      end
      if (MAX_LINE < 4) begin : g_bad_len
         $error("comb3_yc_sep: MAX_LINE must be at least 4");
      end
   endgenerate

   // sample position and fill count
   logic [AW-1:0] pos;
   logic [1:0]    lines_done;
   logic          wrap;
   logic          full;

   assign wrap = (LEN_W'(pos) >= (line_len - LEN_W'(1)));
   assign full = (lines_done == 2'd2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos        <= '0;
         lines_done <= '0;
      end else if (in_valid) begin
         pos <= wrap ? '0 : pos + AW'(1);
         if (wrap && !full)
            lines_done <= lines_done + 2'd1;
      end
   end

   // tap chain: word 0 is the incoming sample
   logic [WW-1:0] tap [N_DLY+1];

   assign tap[0] = bypass_en ? {byp_y, byp_c} : {lo_band, hi_band};

   generate
      for (genvar g = 0; g < N_DLY; g++) begin : g_dly
         comb3_line_delay #(
            .WW   (WW),
            .DEPTH(MAX_LINE),
            .AW   (AW)
         ) i_dly (
            .clk (clk),
            .we  (in_valid),
            .addr(pos),
            .din (tap[g]),
            .dout(tap[g+1])
         );
      end
   endgenerate

   logic signed [DW-1:0] hi_new, hi_mid, hi_old;
   logic [DW-1:0]        lo_mid;
   logic signed [IW-1:0] hy;

   assign hi_new = $signed(tap[0][DW-1:0]);
   assign hi_mid = $signed(tap[1][DW-1:0]);
   assign hi_old = $signed(tap[2][DW-1:0]);
   assign lo_mid = tap[1][WW-1:DW];

   comb3_vweight #(
      .DW   (DW),
      .IW   (IW),
      .ROUND(ROUND)
   ) i_vw (
      .clk     (clk),
      .rst_n   (rst_n),
      .pal_mode(pal_mode),
      .tap_new (hi_new),
      .tap_mid (hi_mid),
      .tap_old (hi_old),
      .hy      (hy)
   );

   int            y_sum, c_sum;
   logic [DW-1:0] y_next, c_next;

   always_comb begin
      y_sum = int'(lo_mid) + int'(hy);
      c_sum = C_ZERO + int'(hi_mid) - int'(hy);
      if (bypass_en) begin
         y_next = tap[1][WW-1:DW];
         c_next = tap[1][DW-1:0];
      end else begin
         y_next = DW'(clip_range(y_sum, MAXV));
         c_next = DW'(clip_range(c_sum, MAXV));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         y_out     <= '0;
         c_out     <= '0;
      end else begin
         out_valid <= in_valid && full;
         if (in_valid) begin
            y_out <= y_next;
            c_out <= c_next;
         end
      end
   end

   // no result while the two delay lines are still filling
   assert_fill_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !full) |=> !out_valid);

   // the fill count saturates at two lines
   assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lines_done <= 2'd2);

   // idle cycles produce nothing and leave the position untouched
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(pos));

   // a wrap returns the position to the line start (R1)
   assert_wrap_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && wrap) |=> (pos == '0));

endmodule

// File: tb/test_comb3_yc_sep.sv
module test_comb3_yc_sep;

   localparam int CLK_PERIOD = 10;
   localparam int MAXL       = 1024;
   localparam int LW         = $clog2(MAXL + 1);
   localparam int HIST       = 512;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [LW-1:0] line_len = LW'(16);
   logic          pal_mode = 1'b0;
   logic          bypass_en = 1'b0;
   logic [7:0]    lo_band = '0, hi_band = '0, byp_y = '0, byp_c = '0;
   logic          out_valid;
   logic [7:0]    y_out, c_out;

   comb3_yc_sep #(.MAX_LINE(MAXL)) i_comb3_yc_sep (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .line_len (line_len),
      .pal_mode (pal_mode),
      .bypass_en(bypass_en),
      .lo_band  (lo_band),
      .hi_band  (hi_band),
      .byp_y    (byp_y),
      .byp_c    (byp_c),
      .out_valid(out_valid),
      .y_out    (y_out),
      .c_out    (c_out)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   typedef struct {
      int    due;
      bit    v;
      int    y;
      int    c;
      string tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   checks = 0;
   int   failures = 0;
   bit   finished = 1'b0;

   int h_lo [HIST];
   int h_hi [HIST];
   int h_by [HIST];
   int h_bc [HIST];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int clip8(input int v);
      return (v < 0) ? 0 : ((v > 255) ? 255 : v);
   endfunction

   // monitor: compare each result one clock after its sample
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (out_valid !== e.v || (e.v && (y_out !== 8'(e.y) || c_out !== 8'(e.c)))) begin
               failures++;
               $display("FAIL %s: valid=%0d y=%0d c=%0d expected valid=%0d y=%0d c=%0d",
                        e.tag, out_valid, y_out, c_out, e.v, e.y, e.c);
            end
         end else if (out_valid === 1'b1) begin
            checks++;
            failures++;
            $display("FAIL R9: valid=1 y=%0d c=%0d expected valid=0 (no sample)", y_out, c_out);
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // kinds: 0 const-colour NTSC, 1 mixed NTSC, 2 PAL, 3 saturation, 4 bypass
   task automatic run_test(input int len, input bit pal, input bit byp, input int nlines,
                           input int kind, input bit gaps, input string tag);
      do_reset();
      line_len  = LW'(len);
      pal_mode  = pal;
      bypass_en = byp;
      for (int n = 0; n < nlines * len; n++) begin
         int   ln, k, s, lo, hi;
         exp_t e;
         ln = n / len;
         k  = n % len;
         case (kind)
            0: begin
               s  = (ln % 2 == 0) ? 1 : -1;
               lo = 100;
               hi = 10 + s * (20 + k);
            end
            1: begin
               lo = (n * 53 + 7) % 256;
               hi = ((n * 29 + 11) % 256) - 128;
            end
            2: begin
               lo = (n * 41 + 3) % 256;
               hi = ((n * 67 + 90) % 256) - 128;
            end
            3: begin
               lo = (ln % 3 == 0) ? 250 : ((ln % 3 == 1) ? 5 : 240);
               hi = (ln % 3 == 0) ? 120 - k : ((ln % 3 == 1) ? -128 : -100 + k);
            end
            default: begin
               lo = (n * 3) % 256;
               hi = ((n * 5) % 256) - 128;
            end
         endcase
         h_lo[n] = lo;
         h_hi[n] = hi;
         h_by[n] = (n * 7) % 256;
         h_bc[n] = (n * 13 + 5) % 256;
         @(negedge clk);
         in_valid = 1'b1;
         lo_band  = 8'(lo);
         hi_band  = 8'(hi);
         byp_y    = 8'(h_by[n]);
         byp_c    = 8'(h_bc[n]);
         e.due = cyc + 1;
         e.tag = tag;
         e.v   = (n >= 2 * len);
         e.y   = 0;
         e.c   = 0;
         if (e.v) begin
            if (byp) begin
               e.y = h_by[n - len];
               e.c = h_bc[n - len];
            end else if (kind == 0) begin
               // R6: luma is flat, chroma is the injected amplitude of the middle line
               s   = (((n - len) / len) % 2 == 0) ? 1 : -1;
               e.y = 110;
               e.c = 128 + s * (20 + k);
            end else begin
               int t0, t1, t2, hy;
               t0 = h_hi[n];
               t1 = h_hi[n - len];
               t2 = h_hi[n - 2 * len];
               hy = pal ? ((t0 + t2 + 1) >>> 1) : ((t0 + 2 * t1 + t2 + 2) >>> 2);
               e.y = clip8(h_lo[n - len] + hy);
               e.c = clip8(128 + t1 - hy);
            end
         end
         q.push_back(e);
         if (gaps && (n % 5 == 4)) begin
            @(negedge clk);
            in_valid = 1'b0;
         end
      end
      idle(3);
   endtask

   initial begin
      do_reset();
      @(negedge clk);
      // R2: reset state
      checks++;
      if (out_valid !== 1'b0 || y_out !== 8'd0 || c_out !== 8'd0) begin
         failures++;
         $display("FAIL R2: valid=%0d y=%0d c=%0d expected valid=0 y=0 c=0", out_valid, y_out, c_out);
      end
      run_test(16, 1'b0, 1'b0, 5, 0, 1'b0, "R6");
      run_test(16, 1'b0, 1'b0, 4, 1, 1'b0, "R3,R5");
      run_test(16, 1'b1, 1'b0, 4, 2, 1'b0, "R4,R5");
      run_test(12, 1'b0, 1'b0, 6, 3, 1'b0, "R8 ntsc");
      run_test(12, 1'b1, 1'b0, 6, 3, 1'b0, "R8 pal");
      run_test(16, 1'b0, 1'b1, 4, 4, 1'b0, "R7");
      run_test(16, 1'b0, 1'b0, 4, 1, 1'b1, "R9");
      run_test(7, 1'b0, 1'b0, 5, 1, 1'b0, "R1 len7");
      run_test(5, 1'b1, 1'b0, 6, 2, 1'b1, "R1 len5");
      run_test(4, 1'b0, 1'b0, 6, 0, 1'b0, "R6 len4");
      // R2: no leftover expectations
      checks++;
      if (q.size() != 0) begin
         failures++;
         $display("FAIL R2: pending results=%0d expected 0", q.size());
      end
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule